// File: doc/BRIEF.md
# Wide Signed Multiply-Accumulate Slice with Cascade Shift

This block is a pipelined signed multiply-accumulate slice. It multiplies a 27-bit signed operand by a 24-bit signed operand. The 51-bit product is sign-extended and added to a second operand in a 58-bit post-adder. The result is held in the P register. The second operand is chosen by a 3-bit opmode. It can be zero, which loads the product. It can be the current P, which accumulates. It can also be a cascade input taken from a neighbouring slice, either as it arrives or arithmetically shifted right by 17 or by 23 bits.

Slices are chained by wiring cascade-out of one slice to cascade-in of the next. With the 17-bit shift, a chain behaves like the older narrow slices. With the 23-bit shift, partial products from the wider B operand can be aligned to build larger multipliers. The 58-bit accumulator has enough headroom to sum 256 full-scale products without wrapping.

Top module: `wmac_top`

## Requirements
- R1: With every clock enable high, A and B applied before rising edge n produce their product at P after edge n+2 (three register stages). The opmode and cascade-in are not delayed: they are sampled at the same edge that loads P.
- R2: Opmode 3'd0 loads P with the sign-extended product. The unused codes 3'd5, 3'd6 and 3'd7 behave like 3'd0.
- R3: Opmode 3'd1 loads P with the previous P plus the product (accumulate).
- R4: Opmode 3'd2 loads P with the product plus cascade-in, with no shift.
- R5: Opmode 3'd3 loads P with the product plus cascade-in arithmetically shifted right by 17 bits, sign bit replicated.
- R6: Opmode 3'd4 loads P with the product plus cascade-in arithmetically shifted right by 23 bits, sign bit replicated.
- R7: Loading one product and then accumulating it 255 more times gives exactly 256 times that product, with no wrap. This holds for positive full-scale products and for negative full-scale products, provided A and B are not both at their most negative values.
- R8: A synchronous reset clears every pipeline register. P reads zero after the reset edge, and a later load with the input and product stages disabled still gives zero.
- R9: Each of the three stages has its own clock enable. While an enable is low, that stage keeps its value.
- R10: Cascade-out is always equal to P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_in | input | 1 | Enable for the A/B input registers |
| ce_mul | input | 1 | Enable for the product register |
| ce_acc | input | 1 | Enable for the P register |
| opmode | input | 3 | Post-adder operand select (0 load, 1 accumulate, 2 cascade, 3 cascade>>>17, 4 cascade>>>23) |
| a_in | input | 27 | Signed multiplicand |
| b_in | input | 24 | Signed multiplier |
| casc_in | input | 58 | Cascade input from the neighbouring slice |
| p_out | output | 58 | Accumulator result |
| casc_out | output | 58 | Cascade output, equal to p_out |

## Verification
A new A/B pair reaches P three rising edges after it is applied. A change of opmode or cascade-in takes effect at the next edge, because both are used directly at the P stage. The bench drives inputs on the falling edge and steps a whole clock before sampling, so every check falls half a period after the edge that produced the value. Each scenario holds A and B for at least three edges before it reads P. Accumulation and clock-enable checks then count single edges from that point.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_ACC      = 3'd1,
        OP_CASC     = 3'd2,
        OP_CASC_S17 = 3'd3,
        OP_CASC_S23 = 3'd4
    } wmac_op_e;

    localparam int SHIFT_NARROW = 17;
    localparam int SHIFT_WIDE   = 23;

endpackage

// File: rtl/wmac_mul.sv
module wmac_mul #(
    parameter int A_W = 27,
    parameter int B_W = 24,
    localparam int M_W = A_W + B_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_in,
    input  logic                  ce_mul,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [B_W-1:0] b_in,
    output logic signed [M_W-1:0] m_out
);

    typedef struct packed {
        logic signed [A_W-1:0] a;
        logic signed [B_W-1:0] b;
        logic signed [M_W-1:0] m;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic signed [M_W-1:0] a_ext, b_ext;

    always_comb begin
        st_d  = st_q;
        a_ext = M_W'(st_q.a);
        b_ext = M_W'(st_q.b);
        if (ce_in) begin
            st_d.a = a_in;
            st_d.b = b_in;
        end
        if (ce_mul) begin
            st_d.m = a_ext * b_ext;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign m_out = st_q.m;

    AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce_in |=> ($stable(st_q.a) && $stable(st_q.b))); // R9

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce_mul |=> $stable(m_out)); // R9

endmodule

// File: rtl/wmac_post.sv
module wmac_post
    import wmac_pkg::*;
#(
    parameter int M_W = 51,
    parameter int P_W = 58
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_acc,
    input  logic [2:0]            opmode,
    input  logic signed [M_W-1:0] m_in,
    input  logic signed [P_W-1:0] casc_in,
    output logic signed [P_W-1:0] p_out
);

    typedef struct packed {
        logic signed [P_W-1:0] p;
    } post_st_t;

    post_st_t st_d, st_q;
    logic signed [P_W-1:0] m_ext;
    logic signed [P_W-1:0] opnd;
    wmac_op_e op;

    assign op    = wmac_op_e'(opmode);
    assign m_ext = P_W'(m_in);

    always_comb begin
        case (op)
            OP_ACC:      opnd = st_q.p;
            OP_CASC:     opnd = casc_in;
            OP_CASC_S17: opnd = casc_in >>> SHIFT_NARROW;
            OP_CASC_S23: opnd = casc_in >>> SHIFT_WIDE;
            default:     opnd = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ce_acc) begin
            st_d.p = m_ext + opnd;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign p_out = st_q.p;

    AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (ce_acc && opmode == 3'd0) |=> p_out == $past(m_ext)); // R2

    AST_ACCUMULATE: assert property (@(posedge clk) disable iff (rst)
        (ce_acc && opmode == 3'd1) |=> p_out == $past(p_out) + $past(m_ext)); // R3

    AST_CASC_SHIFT17: assert property (@(posedge clk) disable iff (rst)
        (ce_acc && opmode == 3'd3) |=> p_out == $past(m_ext) + ($past(casc_in) >>> 17)); // R5

    AST_CASC_SHIFT23: assert property (@(posedge clk) disable iff (rst)
        (ce_acc && opmode == 3'd4) |=> p_out == $past(m_ext) + ($past(casc_in) >>> 23)); // R6

    AST_P_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce_acc |=> $stable(p_out)); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> p_out == '0); // R8

endmodule

// File: rtl/wmac_top.sv
module wmac_top #(
    parameter int A_W = 27,
    parameter int B_W = 24,
    parameter int P_W = 58,
    localparam int M_W = A_W + B_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce_in,
    input  logic                  ce_mul,
    input  logic                  ce_acc,
    input  logic [2:0]            opmode,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [B_W-1:0] b_in,
    input  logic signed [P_W-1:0] casc_in,
    output logic signed [P_W-1:0] p_out,
    output logic signed [P_W-1:0] casc_out
);

    logic signed [M_W-1:0] m_w;

    wmac_mul #(.A_W(A_W), .B_W(B_W)) i_mul (
        .clk    (clk),
        .rst    (rst),
        .ce_in  (ce_in),
        .ce_mul (ce_mul),
        .a_in   (a_in),
        .b_in   (b_in),
        .m_out  (m_w)
    );

    wmac_post #(.M_W(M_W), .P_W(P_W)) i_post (
        .clk     (clk),
        .rst     (rst),
        .ce_acc  (ce_acc),
        .opmode  (opmode),
        .m_in    (m_w),
        .casc_in (casc_in),
        .p_out   (p_out)
    );

    assign casc_out = p_out;

endmodule

// File: tb/test_wmac_top.sv
`timescale 1ns/1ps
module test_wmac_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_in = 1'b1, ce_mul = 1'b1, ce_acc = 1'b1;
    logic [2:0] opmode = 3'd0;
    logic signed [26:0] a_in = '0;
    logic signed [23:0] b_in = '0;
    logic signed [57:0] casc_in = '0;
    logic signed [57:0] p_out, casc_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wmac_top i_wmac_top (
        .clk(clk), .rst(rst), .ce_in(ce_in), .ce_mul(ce_mul), .ce_acc(ce_acc),
        .opmode(opmode), .a_in(a_in), .b_in(b_in), .casc_in(casc_in),
        .p_out(p_out), .casc_out(casc_out)
    );

    function automatic logic signed [57:0] prod(input logic signed [26:0] a,
                                                input logic signed [23:0] b);
        logic signed [57:0] ax, bx;
        ax = a;
        bx = b;
        return ax * bx;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic signed [57:0] act,
                       input logic signed [57:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setab(input logic signed [26:0] a, input logic signed [23:0] b,
                         input logic [2:0] op, input logic signed [57:0] c);
        a_in = a; b_in = b; opmode = op; casc_in = c;
    endtask

    task automatic t_reset;
        setab(27'sd1234, 24'sd77, 3'd0, '0);
        rst = 1'b1;
        step(1);
        chk("R8 reset P", p_out, 0);
        rst = 1'b0;
        ce_in = 1'b0; ce_mul = 1'b0; ce_acc = 1'b1;
        step(1);
        chk("R8 cleared product", p_out, 0);
        ce_in = 1'b1; ce_mul = 1'b1;
    endtask

    task automatic t_latency;
        setab(-27'sd5000, 24'sd300, 3'd0, '0);
        step(2);
        chk("R1 not yet at edge 2", p_out, 0);
        step(1);
        chk("R1 product at edge 3", p_out, prod(-27'sd5000, 24'sd300));
        chk("R10 cascade-out", casc_out, p_out);
    endtask

    task automatic t_load_codes;
        setab(27'sd33, -24'sd9, 3'd5, 58'sd999);
        step(3);
        chk("R2 code 5", p_out, prod(27'sd33, -24'sd9));
        opmode = 3'd7;
        step(1);
        chk("R2 code 7", p_out, prod(27'sd33, -24'sd9));
    endtask

    task automatic t_accumulate;
        logic signed [57:0] pp;
        pp = prod(27'sd4001, -24'sd123);
        setab(27'sd4001, -24'sd123, 3'd0, '0);
        step(3);
        opmode = 3'd1;
        step(2);
        chk("R3 accumulate x3", p_out, 3 * pp);
        chk("R10 cascade-out acc", casc_out, 3 * pp);
    endtask

    task automatic t_cascade;
        logic signed [57:0] pp, c;
        pp = prod(-27'sd777, -24'sd4321);
        c  = -58'sd123456789012345;
        setab(-27'sd777, -24'sd4321, 3'd2, c);
        step(3);
        chk("R4 cascade unshifted", p_out, pp + c);
        opmode = 3'd3;
        step(1);
        chk("R5 cascade >>>17 negative", p_out, pp + (c >>> 17));
        opmode = 3'd4;
        step(1);
        chk("R6 cascade >>>23 negative", p_out, pp + (c >>> 23));
        c = 58'sh0ff_ffff_ffff_fff;
        casc_in = c;
        step(1);
        chk("R6 cascade >>>23 positive", p_out, pp + (c >>> 23));
        opmode = 3'd3;
        step(1);
        chk("R5 cascade >>>17 positive", p_out, pp + (c >>> 17));
    endtask

    task automatic t_overflow;
        logic signed [57:0] pp;
        pp = prod(27'sh3ff_ffff, 24'sh7f_ffff);
        setab(27'sh3ff_ffff, 24'sh7f_ffff, 3'd0, '0);
        step(3);
        opmode = 3'd1;
        step(255);
        chk("R7 256 positive products", p_out, 256 * pp);
        pp = prod(-27'sh400_0000, 24'sh7f_ffff);
        setab(-27'sh400_0000, 24'sh7f_ffff, 3'd0, '0);
        step(3);
        opmode = 3'd1;
        step(255);
        chk("R7 256 negative products", p_out, 256 * pp);
    endtask

    task automatic t_enables;
        logic signed [57:0] held, old;
        setab(27'sd10, 24'sd20, 3'd0, '0);
        step(3);
        held = p_out;
        ce_acc = 1'b0;
        setab(27'sd99, 24'sd99, 3'd2, 58'sd55555);
        step(4);
        chk("R9 P held", p_out, held);
        ce_acc = 1'b1;
        setab(27'sd10, 24'sd20, 3'd0, '0);
        step(3);
        old = p_out;
        ce_in = 1'b0;
        setab(27'sd1000, 24'sd1000, 3'd0, '0);
        step(3);
        chk("R9 input regs held", p_out, old);
        ce_in = 1'b1; ce_mul = 1'b0;
        step(3);
        chk("R9 product reg held", p_out, old);
        ce_mul = 1'b1;
        step(2);
        chk("R9 resumes", p_out, prod(27'sd1000, 24'sd1000));
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_load_codes();
        t_accumulate();
        t_cascade();
        t_overflow();
        t_enables();
        rst = 1'b1;
        step(1);
        chk("R8 reset mid-run", p_out, 0);
        chk("R10 cascade-out after reset", casc_out, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule